// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM. The RAM holds 16-bit words and has a separate select for each byte. The host issues one read or one write at a time. Each request carries an 18-bit word address, 16 bits of write data and a 2-bit byte mask. The controller turns that request into a sequence of registered, glitch-free control strobes. Every phase of that sequence lasts a whole number of clock cycles, and each count is derived from a nanosecond parameter and the clock period.

A write follows the memory's overlap rule. Chip select and the selected byte lanes go low first. The write strobe then goes low for the programmed pulse length. The write ends when the write strobe alone rises, while chip select, lanes, address and data stay unchanged for one more cycle. A read holds the output gate low for the access time and captures the data bus on the last cycle of that access. The captured word is returned with a one-cycle valid pulse, and the bus float time is observed before the controller drives the data bus again.

Each phase count is `max(1, ceil(ns / CLK_NS))`. With the default 4 ns clock and the fast-grade values, the counts are as follows:
- write strobe: 12 cycles
- read access: 14 cycles
- float time: 5 cycles
- one access takes at least 14 cycles from start to end

Top module: `asram_ctrl`

## Requirements
- R1: Whenever `host_busy` is low, including right after reset, `sram_cs_n`, `sram_hib_n`, `sram_lob_n`, `sram_wstb_n` and `sram_ogate_n` are all 1 and `sram_drive` is 0.
- R2: `sram_wstb_n` is low only while `sram_cs_n` is low, at least one lane select is low, `sram_ogate_n` is high and `sram_drive` is high.
- R3: A write ends with `sram_wstb_n` rising. In that cycle `sram_cs_n` is low and the lane selects, `sram_addr` and `sram_dout` keep their previous values with the bus still driven. The memory then stores the held data at the held address.
- R4: The write strobe stays low for exactly N_WP cycles, where N_WP is the largest of the cycle counts for the write-pulse, address-to-end and data-setup times (12 at defaults).
- R5: `sram_ogate_n` is low only while `sram_cs_n` is low, `sram_wstb_n` is high and the bus is not driven. It stays low for N_RD cycles, the largest of the address, output-gate and lane access counts (14 at defaults). The data bus is captured at the clock edge that ends the last of those cycles.
- R6: After `sram_ogate_n` rises, `sram_drive` does not rise until at least N_HZ = ceil(float time) cycles have passed (5 at defaults).
- R7: Mask bit 0 drives `sram_lob_n` and governs data bits 7:0. Mask bit 1 drives `sram_hib_n` and governs bits 15:8. During an access the lane select is low exactly for set mask bits, and a write changes only those lanes in memory.
- R8: A read returns `host_rdata` with `host_rvalid` high for exactly one cycle. Lanes whose mask bit is clear read as zero.
- R9: Address, data and mask are registered when the request is accepted and held until the access ends. `host_busy` stays high from acceptance through the last recovery cycle. A write is busy for 2+N_WP+N_WREC cycles and a read for N_RD+N_RREC cycles, which is 15 and 19 at defaults. Each access covers at least the cycle time.
- R10: A request raised while `host_busy` is high is ignored and does not change the memory or the length of the running access.
- R11: A request with byte mask 00 keeps busy high for one cycle and produces no strobe. If it is a read, it returns `host_rvalid` for one cycle with `host_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, accepted when not busy |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_bmask | input | 2 | Byte mask, bit 0 = low byte |
| host_busy | output | 1 | Access in progress |
| host_rdata | output | 16 | Read data, masked |
| host_rvalid | output | 1 | One-cycle read data valid |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_wstb_n | output | 1 | Write strobe, active low |
| sram_ogate_n | output | 1 | Output gate, active low |
| sram_hib_n | output | 1 | Upper byte select, active low |
| sram_lob_n | output | 1 | Lower byte select, active low |
| sram_addr | output | 18 | Memory address |
| sram_dout | output | 16 | Data toward memory |
| sram_din | input | 16 | Data from memory |
| sram_drive | output | 1 | Drive enable for the data bus |

## Verification
A wrong phase counter shows up at the memory strobes within one access. The write strobe is too short, the access ends before data is valid so junk is captured, or the bus is driven inside the float window. A wrong lane or mask register shows as a lane select that does not match the requested mask during the same access, and as bad data on the following read. A wrong state transition shows as a busy length that differs from the derived count, or as a missing or doubled valid pulse, and is seen at the end of that same request.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_ACCESS,
    ST_RECOV
  } asram_state_e;

  // cycles needed to cover a time, never fewer than one
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    return max2(max2(a, b), c);
  endfunction

  // remainder of a minimum cycle once other phases are spent, at least one
  function automatic int unsigned rest(int unsigned total, int unsigned used);
    return (total > used) ? (total - used) : 1;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (!zero)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_nxt,
  input  logic [LANES-1:0]         mask_nxt,
  input  logic [LANES-1:0]         mask_q,
  input  logic                     cap_en,
  input  logic                     zero_en,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES-1:0]         lane_n,
  output logic [LANES*LANE_W-1:0]  rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              sel_n_q;
    logic [LANE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst) sel_n_q <= 1'b1;
      else     sel_n_q <= !(sel_nxt && mask_nxt[l]);
    end

    always_ff @(posedge clk) begin
      if (rst)          byte_q <= '0;
      else if (cap_en)  byte_q <= mask_q[l] ? din[l*LANE_W +: LANE_W] : '0;
      else if (zero_en) byte_q <= '0;
    end

    assign lane_n[l]                  = sel_n_q;
    assign rdata[l*LANE_W +: LANE_W]  = byte_q;
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 8,
  parameter int CLK_NS        = 4,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_WPULSE_NS   = 45,
  parameter int T_AWEND_NS    = 45,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_ADDR_ACC_NS = 55,
  parameter int T_OG_ACC_NS   = 25,
  parameter int T_LANE_ACC_NS = 25,
  parameter int T_FLOAT_NS    = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_req,
  input  logic                         host_wr,
  input  logic [ADDR_W-1:0]            host_addr,
  input  logic [DATA_W-1:0]            host_wdata,
  input  logic [DATA_W/LANE_W-1:0]     host_bmask,
  output logic                         host_busy,
  output logic [DATA_W-1:0]            host_rdata,
  output logic                         host_rvalid,
  output logic                         sram_cs_n,
  output logic                         sram_wstb_n,
  output logic                         sram_ogate_n,
  output logic                         sram_hib_n,
  output logic                         sram_lob_n,
  output logic [ADDR_W-1:0]            sram_addr,
  output logic [DATA_W-1:0]            sram_dout,
  input  logic [DATA_W-1:0]            sram_din,
  output logic                         sram_drive
);
  import asram_pkg::*;

  localparam int LANES   = DATA_W / LANE_W;
  localparam int N_RC    = ns2cyc(T_CYCLE_NS, CLK_NS);
  localparam int N_WP    = max3(ns2cyc(T_WPULSE_NS, CLK_NS), ns2cyc(T_AWEND_NS, CLK_NS),
                                ns2cyc(T_DSETUP_NS, CLK_NS));
  localparam int N_RD    = max3(ns2cyc(T_ADDR_ACC_NS, CLK_NS), ns2cyc(T_OG_ACC_NS, CLK_NS),
                                ns2cyc(T_LANE_ACC_NS, CLK_NS));
  localparam int N_HZ    = ns2cyc(T_FLOAT_NS, CLK_NS);
  localparam int N_WREC  = rest(N_RC, N_WP + 2);
  localparam int N_RREC  = max2(N_HZ, rest(N_RC, N_RD));
  localparam int CNT_MAX = max2(max3(N_WP, N_RD, N_WREC), N_RREC);
  localparam int CW      = $clog2(CNT_MAX + 1);

  asram_state_e st_q, st_nxt;
  logic          load;
  logic [CW-1:0] load_val;
  logic          cnt_zero;
  logic          accept;
  logic          sel_nxt;
  logic [LANES-1:0] mask_q, mask_nxt;
  logic [LANES-1:0] lane_n;
  logic          cap_en, zero_en;

  assign accept   = (st_q == ST_IDLE) && host_req;
  assign mask_nxt = accept ? host_bmask : mask_q;
  assign cap_en   = (st_q == ST_ACCESS) && cnt_zero;
  assign zero_en  = accept && (host_bmask == '0) && !host_wr;

  always_comb begin
    st_nxt   = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (host_bmask == '0) st_nxt = ST_SKIP;
        else if (host_wr)     st_nxt = ST_SETUP;
        else begin
          st_nxt = ST_ACCESS; load = 1'b1; load_val = CW'(N_RD - 1);
        end
      end
      ST_SKIP:   st_nxt = ST_IDLE;
      ST_SETUP: begin
        st_nxt = ST_STROBE; load = 1'b1; load_val = CW'(N_WP - 1);
      end
      ST_STROBE: if (cnt_zero) st_nxt = ST_HOLD;
      ST_HOLD: begin
        st_nxt = ST_RECOV; load = 1'b1; load_val = CW'(N_WREC - 1);
      end
      ST_ACCESS: if (cnt_zero) begin
        st_nxt = ST_RECOV; load = 1'b1; load_val = CW'(N_RREC - 1);
      end
      ST_RECOV:  if (cnt_zero) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  assign sel_nxt = (st_nxt == ST_SETUP) || (st_nxt == ST_STROBE) ||
                   (st_nxt == ST_HOLD)  || (st_nxt == ST_ACCESS);

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      host_busy    <= 1'b0;
      host_rvalid  <= 1'b0;
      sram_cs_n    <= 1'b1;
      sram_wstb_n  <= 1'b1;
      sram_ogate_n <= 1'b1;
      sram_drive   <= 1'b0;
      sram_addr    <= '0;
      sram_dout    <= '0;
      mask_q       <= '0;
    end else begin
      st_q         <= st_nxt;
      host_busy    <= (st_nxt != ST_IDLE);
      host_rvalid  <= cap_en || zero_en;
      sram_cs_n    <= !sel_nxt;
      sram_wstb_n  <= (st_nxt != ST_STROBE);
      sram_ogate_n <= (st_nxt != ST_ACCESS);
      sram_drive   <= (st_nxt == ST_SETUP) || (st_nxt == ST_STROBE) || (st_nxt == ST_HOLD);
      if (accept) begin
        sram_addr <= host_addr;
        sram_dout <= host_wdata;
        mask_q    <= host_bmask;
      end
    end
  end

  asram_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst(rst), .sel_nxt(sel_nxt), .mask_nxt(mask_nxt), .mask_q(mask_q),
    .cap_en(cap_en), .zero_en(zero_en), .din(sram_din), .lane_n(lane_n),
    .rdata(host_rdata)
  );

  assign sram_lob_n = lane_n[0];
  assign sram_hib_n = lane_n[LANES-1];
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int N_WP = 12,
  parameter int N_HZ = 5,
  parameter int AW   = 18,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          host_busy,
  input logic          host_rvalid,
  input logic          sram_cs_n,
  input logic          sram_wstb_n,
  input logic          sram_ogate_n,
  input logic          sram_hib_n,
  input logic          sram_lob_n,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dout,
  input logic          sram_drive
);
  localparam int LW = $clog2(N_WP + 2);
  localparam int HW = $clog2(N_HZ + 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hz_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (sram_wstb_n) low_cnt <= '0;
    else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) hz_cnt <= HW'(N_HZ);
    else if (!sram_ogate_n) hz_cnt <= '0;
    else if (hz_cnt != HW'(N_HZ)) hz_cnt <= hz_cnt + 1'b1;
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !host_busy |-> (sram_cs_n && sram_hib_n && sram_lob_n && sram_wstb_n && sram_ogate_n && !sram_drive));

  // R2
  write_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_wstb_n |-> (!sram_cs_n && !(sram_hib_n && sram_lob_n) && sram_ogate_n && sram_drive));

  // R3
  write_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_wstb_n) |-> (!sram_cs_n && sram_drive && $stable(sram_hib_n) && $stable(sram_lob_n)
                            && $stable(sram_addr) && $stable(sram_dout)));

  // R4
  wpulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_wstb_n) |-> (low_cnt == LW'(N_WP)));

  // R5
  read_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_ogate_n |-> (!sram_cs_n && sram_wstb_n && !sram_drive));

  // R6
  float_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_drive) |-> (hz_cnt >= HW'(N_HZ)));

  // R8
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  // R9
  held_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (host_busy && $past(host_busy)) |-> ($stable(sram_addr) && $stable(sram_dout)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.N_WP(N_WP), .N_HZ(N_HZ), .AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_busy(host_busy), .host_rvalid(host_rvalid),
  .sram_cs_n(sram_cs_n), .sram_wstb_n(sram_wstb_n), .sram_ogate_n(sram_ogate_n),
  .sram_hib_n(sram_hib_n), .sram_lob_n(sram_lob_n), .sram_addr(sram_addr),
  .sram_dout(sram_dout), .sram_drive(sram_drive)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  localparam int CLK = 4;

  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NWP    = mx(mx(cyc(45), cyc(45)), cyc(25));
  localparam int NRD    = mx(mx(cyc(55), cyc(25)), cyc(25));
  localparam int NHZ    = cyc(20);
  localparam int BUSY_W = 2 + NWP + mx(1, cyc(55) - NWP - 2);
  localparam int BUSY_R = NRD + mx(NHZ, mx(1, cyc(55) - NRD));
  localparam int ACC_OK = 55 / CLK;

  logic clk = 0, rst = 1;
  logic host_req = 0, host_wr = 0;
  logic [17:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_bmask = '0;
  logic host_busy, host_rvalid;
  logic [15:0] host_rdata;
  logic sram_cs_n, sram_wstb_n, sram_ogate_n, sram_hib_n, sram_lob_n, sram_drive;
  logic [17:0] sram_addr;
  logic [15:0] sram_dout, sram_din;

  always #(CLK/2) clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_bmask(host_bmask), .host_busy(host_busy),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sram_cs_n(sram_cs_n),
    .sram_wstb_n(sram_wstb_n), .sram_ogate_n(sram_ogate_n), .sram_hib_n(sram_hib_n),
    .sram_lob_n(sram_lob_n), .sram_addr(sram_addr), .sram_dout(sram_dout),
    .sram_din(sram_din), .sram_drive(sram_drive)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] rd_word;
  int  wlow = 0, acc = 0, hz = 100;
  int  n_wend = 0, n_rd = 0;
  bit  drive_prev = 0, ogate_prev = 1, lane_err = 0;
  logic [1:0] cur_mask = 0;

  function automatic logic [15:0] look(logic [15:0] m [int], int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    rd_word <= look(mem, int'(sram_addr));
    if (!rst) begin
      if (!sram_wstb_n) wlow <= wlow + 1;
      else if (wlow != 0) begin
        chk(wlow >= NWP, "R4 strobe length", wlow, NWP);
        chk(!sram_cs_n && sram_drive, "R3 select held at write end", sram_cs_n, 0);
        begin
          logic [15:0] w;
          w = look(mem, int'(sram_addr));
          if (!sram_lob_n) w[7:0]  = sram_dout[7:0];
          if (!sram_hib_n) w[15:8] = sram_dout[15:8];
          mem[int'(sram_addr)] = w;
        end
        n_wend <= n_wend + 1;
        wlow <= 0;
      end
      if (!sram_wstb_n && (sram_cs_n || !sram_ogate_n || !sram_drive)) lane_err <= 1;   // R2
      if (!sram_ogate_n) acc <= acc + 1; else acc <= 0;
      if (!sram_ogate_n && ogate_prev) n_rd <= n_rd + 1;
      if (!sram_ogate_n) hz <= 0; else if (hz < 100) hz <= hz + 1;
      if (sram_drive && !drive_prev) chk(hz >= NHZ, "R6 float wait", hz, NHZ);
      if (sram_drive && !sram_ogate_n) chk(0, "R5 drive during read", 1, 0);
      if (!sram_cs_n && ({sram_hib_n, sram_lob_n} != ~cur_mask)) lane_err <= 1;
      drive_prev <= sram_drive;
      ogate_prev <= sram_ogate_n;
    end
  end

  always_comb begin
    bit on;
    on = !sram_cs_n && !sram_ogate_n && sram_wstb_n && (acc >= ACC_OK);
    sram_din[7:0]  = (on && !sram_lob_n) ? rd_word[7:0]  : 8'h5A;
    sram_din[15:8] = (on && !sram_hib_n) ? rd_word[15:8] : 8'hA5;
  end

  task automatic idle_chk(string tag);
    chk(sram_cs_n && sram_hib_n && sram_lob_n && sram_wstb_n && sram_ogate_n && !sram_drive,
        tag, {sram_cs_n, sram_hib_n, sram_lob_n, sram_wstb_n, sram_ogate_n, sram_drive}, 6'b111110);
  endtask

  task automatic op(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] m, bit poke);
    int nb, nv, ew, er;
    logic [15:0] got, exp;
    @(negedge clk);
    while (host_busy) @(negedge clk);
    cur_mask = m; lane_err = 0;
    ew = n_wend; er = n_rd;
    host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; host_bmask = m;
    @(negedge clk);
    host_req = 0; host_addr = ~a; host_wdata = ~d; host_bmask = ~m;
    nb = 0; nv = 0; got = 16'hFFFF;
    while (host_busy) begin
      nb++;
      if (host_rvalid) begin nv++; got = host_rdata; end
      if (poke && nb == 3) begin
        host_req = 1; host_wr = 1; host_addr = a ^ 18'h00F0F; host_wdata = 16'hBEEF; host_bmask = 2'b11;
      end else host_req = 0;
      @(negedge clk);
    end
    host_req = 0;
    if (m == 2'b00) begin
      chk(nb == 1, "R11 mask00 busy", nb, 1);
      chk(n_wend == ew && n_rd == er, "R11 mask00 no strobe", n_wend - ew + n_rd - er, 0);
      if (!wr) chk(nv == 1 && got == 0, "R11 mask00 read zero", got, 0);
    end else begin
      chk(nb == (wr ? BUSY_W : BUSY_R), "R9 busy length", nb, wr ? BUSY_W : BUSY_R);
      chk(!lane_err, "R7 lane selects match mask", lane_err, 0);
      if (wr) begin
        exp = look(shadow, int'(a));
        if (m[0]) exp[7:0]  = d[7:0];
        if (m[1]) exp[15:8] = d[15:8];
        shadow[int'(a)] = exp;
      end else begin
        exp = look(shadow, int'(a));
        exp = {m[1] ? exp[15:8] : 8'h00, m[0] ? exp[7:0] : 8'h00};
        chk(nv == 1, "R8 single valid pulse", nv, 1);
        chk(got == exp, "R8 read data", got, exp);
      end
    end
    chk(!host_rvalid, "R8 valid gone after access", host_rvalid, 0);
    idle_chk("R1 idle after access");
  endtask

  initial begin
    #(200000 * CLK);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [17:0] addrs [5];
    addrs[0] = 18'h00000; addrs[1] = 18'h00001; addrs[2] = 18'h15555;
    addrs[3] = 18'h2AAAA; addrs[4] = 18'h3FFFF;
    repeat (3) @(negedge clk);
    idle_chk("R1 reset state");
    chk(!host_busy && !host_rvalid, "R1 reset busy/valid", host_busy, 0);
    rst = 0;
    for (int i = 0; i < 5; i++) op(1, addrs[i], addrs[i][15:0] ^ 16'h3C96, 2'b11, 0);
    for (int i = 0; i < 5; i++) begin
      for (int wm = 0; wm < 4; wm++) begin
        op(1, addrs[i], 16'h1000 * (i + 1) + 16'h0111 * wm + 16'h8008, 2'(wm), 0);   // R3 R7
        for (int rm = 0; rm < 4; rm++) op(0, addrs[i], 16'h0, 2'(rm), 0);            // R5 R8
      end
    end
    // R10: request during busy is ignored
    op(1, 18'h00100, 16'h1234, 2'b11, 0);
    op(1, 18'h00100 ^ 18'h00F0F, 16'h5678, 2'b11, 0);
    op(1, 18'h00100, 16'hCAFE, 2'b01, 1);
    op(0, 18'h00100 ^ 18'h00F0F, 16'h0, 2'b11, 0);
    op(0, 18'h00100, 16'h0, 2'b11, 1);
    op(0, 18'h00100 ^ 18'h00F0F, 16'h0, 2'b11, 0);
    chk(look(mem, int'(18'h00100 ^ 18'h00F0F)) == 16'h5678, "R10 poke ignored",
        look(mem, int'(18'h00100 ^ 18'h00F0F)), 16'h5678);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule